// File: doc/BRIEF.md
# Producer-Tag Register Rename Table

This block keeps, for every architectural register, the sequence tag of the youngest in-flight instruction that will write it. When an instruction is presented for renaming, the block looks up the producer of each of its sources, and a source counts as ready if no producer is in flight or if that producer has already written back. If the producer has not yet written back, the block reports a dependent link that names the producer's tag, so that wakeup logic elsewhere can attach the instruction to it. In the same cycle the destination entry's previous contents are reported for recovery, and on the next clock edge the entry takes the new instruction's tag.

A small scoreboard holds one result-ready bit per tag. A writeback port sets the bit, and allocating a tag to a new destination clears it. On a squash, the back end supplies its committed copy of the table and the whole table is overwritten in a single cycle, so there is no history walk-back. All lookup outputs are combinational from registered state. Neither the table nor the scoreboard is bypassed from the same cycle's writes.

Top module: `producer_tag_rename`

## Requirements
- R1: After reset, every table entry holds no producer: every source reads as ready with no dependent link, and no previous producer is reported.
- R2: A source whose valid bit is low is reported as ready with no dependent link, whatever its register holds. An instruction with no sources is therefore fully ready.
- R3: For a valid source whose entry holds a producer, the source is ready when that producer's ready bit is set. Otherwise `depValid` is high, `depTag` gives the producer tag and `srcReady` is low. A valid source whose entry is empty is ready.
- R4: For a rename with a destination, `prevValid`/`prevTag` show the destination entry's old contents in the same cycle. From the next cycle the entry holds `renTag`.
- R5: Sources are looked up before the destination is written, so an instruction that reads and writes the same register depends on the older producer, not on itself.
- R6: A writeback sets the ready bit of `wbTag` from the next cycle. A rename with a destination clears the ready bit of `renTag`. If both name the same tag in one cycle, the clear wins.
- R7: A squash overwrites the whole table with `commitTable` for the next cycle. Entry r sits at bits [r*(TAG_W+1) +: TAG_W+1], with the MSB as the producer-valid flag and the low TAG_W bits as the tag. A rename in the same cycle as a squash does not write the table and reports no previous producer.
- R8: While `renValid` is low, `depValid` and `prevValid` stay low and the table is left unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| renValid | input | 1 | An instruction is being renamed this cycle |
| renTag | input | TAG_W | Sequence tag of the instruction being renamed |
| srcValid | input | 2 | Per-source valid bits |
| srcIdx | input | 2*IDX_W | Source architectural registers; source s sits at [s*IDX_W +: IDX_W] |
| dstValid | input | 1 | The instruction writes a destination |
| dstIdx | input | IDX_W | Destination architectural register |
| wbValid | input | 1 | A producer has written back |
| wbTag | input | TAG_W | Tag of the producer that wrote back |
| squash | input | 1 | Restore the table from the committed copy |
| commitTable | input | NUM_ARCH*(TAG_W+1) | Committed table, packed one entry per register |
| srcReady | output | 2 | Per-source ready flag |
| depValid | output | 2 | Per-source dependent link present |
| depTag | output | 2*TAG_W | Producer tag for each source |
| prevValid | output | 1 | The destination had a previous producer |
| prevTag | output | TAG_W | Previous producer tag of the destination |

## Verification
The bench builds the block with the default parameters: eight architectural registers and four-bit tags. With eight registers, one packed committed table can set every entry at once, so a single squash shows restored producers next to cleared entries. With sixteen tags, the directed sequences can use distinct tags for each scenario and never reuse a live one. Under these values the bench reaches same-register read-and-write, a writeback that collides with a new allocation, and a squash that coincides with a rename.

// File: rtl/rename_pkg.sv
package rename_pkg;

  // Strobes from the control to the datapath for one cycle.
  typedef struct packed {
    logic       restore;     // bulk copy of the committed table
    logic       writeDst;    // overwrite the destination entry
    logic       setReady;    // mark a written-back tag ready
    logic       clearReady;  // mark a freshly allocated tag not ready
    logic [1:0] lookupEn;    // per-source lookup enable
  } renStrobe_t;

endpackage

// File: rtl/rename_ctrl.sv
module rename_ctrl
  import rename_pkg::*;
(
  input  logic       renValid,
  input  logic [1:0] srcValid,
  input  logic       dstValid,
  input  logic       wbValid,
  input  logic       squash,
  output renStrobe_t strobe
);

  logic allocate;

  // A squash takes priority over any rename presented in the same cycle.
  assign allocate = renValid && dstValid && !squash;

  always_comb begin
    strobe            = '0;
    strobe.restore    = squash;
    strobe.writeDst   = allocate;
    strobe.clearReady = allocate;
    strobe.setReady   = wbValid;
    strobe.lookupEn   = renValid ? srcValid : 2'b00;
  end

endmodule

// File: rtl/rename_datapath.sv
module rename_datapath
  import rename_pkg::*;
#(
  parameter int NUM_ARCH = 8,
  parameter int TAG_W    = 4,
  localparam int IDX_W    = $clog2(NUM_ARCH),
  localparam int ENT_W    = TAG_W + 1,
  localparam int NUM_TAGS = 1 << TAG_W
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  renStrobe_t                strobe,
  input  logic [TAG_W-1:0]          renTag,
  input  logic [2*IDX_W-1:0]        srcIdx,
  input  logic [IDX_W-1:0]          dstIdx,
  input  logic [TAG_W-1:0]          wbTag,
  input  logic [NUM_ARCH*ENT_W-1:0] commitTable,
  output logic [1:0]                srcReady,
  output logic [1:0]                depValid,
  output logic [2*TAG_W-1:0]        depTag,
  output logic                      prevValid,
  output logic [TAG_W-1:0]          prevTag,
  output logic [NUM_ARCH*ENT_W-1:0] tableFlat
);

  logic [ENT_W-1:0]    tableQ [NUM_ARCH];
  logic [NUM_TAGS-1:0] readyQ;
  logic [ENT_W-1:0]    oldEntry;

  // Producer table: a restore wins over a destination write.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int r = 0; r < NUM_ARCH; r++) tableQ[r] <= '0;
    end else if (strobe.restore) begin
      for (int r = 0; r < NUM_ARCH; r++) tableQ[r] <= commitTable[r*ENT_W +: ENT_W];
    end else if (strobe.writeDst) begin
      tableQ[dstIdx] <= {1'b1, renTag};
    end
  end

  // Result-ready scoreboard: the clear comes last, so allocation wins.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      readyQ <= '0;
    end else begin
      if (strobe.setReady)   readyQ[wbTag]  <= 1'b1;
      if (strobe.clearReady) readyQ[renTag] <= 1'b0;
    end
  end

  // Source lookups read pre-update state.
  for (genvar s = 0; s < 2; s++) begin : g_src
    logic [ENT_W-1:0] srcEntry;
    logic             pending;
    assign srcEntry = tableQ[srcIdx[s*IDX_W +: IDX_W]];
    assign pending  = strobe.lookupEn[s] && srcEntry[TAG_W] &&
                      !readyQ[srcEntry[TAG_W-1:0]];
    assign depValid[s]               = pending;
    assign srcReady[s]               = !pending;
    assign depTag[s*TAG_W +: TAG_W]  = srcEntry[TAG_W-1:0];
  end

  assign oldEntry  = tableQ[dstIdx];
  assign prevValid = strobe.writeDst && oldEntry[TAG_W];
  assign prevTag   = oldEntry[TAG_W-1:0];

  for (genvar r = 0; r < NUM_ARCH; r++) begin : g_flat
    assign tableFlat[r*ENT_W +: ENT_W] = tableQ[r];
  end

endmodule

// File: rtl/producer_tag_rename.sv
module producer_tag_rename
  import rename_pkg::*;
#(
  parameter int NUM_ARCH = 8,
  parameter int TAG_W    = 4,
  localparam int IDX_W   = $clog2(NUM_ARCH),
  localparam int ENT_W   = TAG_W + 1
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic                      renValid,
  input  logic [TAG_W-1:0]          renTag,
  input  logic [1:0]                srcValid,
  input  logic [2*IDX_W-1:0]        srcIdx,
  input  logic                      dstValid,
  input  logic [IDX_W-1:0]          dstIdx,
  input  logic                      wbValid,
  input  logic [TAG_W-1:0]          wbTag,
  input  logic                      squash,
  input  logic [NUM_ARCH*ENT_W-1:0] commitTable,
  output logic [1:0]                srcReady,
  output logic [1:0]                depValid,
  output logic [2*TAG_W-1:0]        depTag,
  output logic                      prevValid,
  output logic [TAG_W-1:0]          prevTag
);

  renStrobe_t                strobe;
  logic [NUM_ARCH*ENT_W-1:0] tableFlat;

  rename_ctrl u_ctrl (
    .renValid (renValid),
    .srcValid (srcValid),
    .dstValid (dstValid),
    .wbValid  (wbValid),
    .squash   (squash),
    .strobe   (strobe)
  );

  rename_datapath #(.NUM_ARCH(NUM_ARCH), .TAG_W(TAG_W)) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .strobe      (strobe),
    .renTag      (renTag),
    .srcIdx      (srcIdx),
    .dstIdx      (dstIdx),
    .wbTag       (wbTag),
    .commitTable (commitTable),
    .srcReady    (srcReady),
    .depValid    (depValid),
    .depTag      (depTag),
    .prevValid   (prevValid),
    .prevTag     (prevTag),
    .tableFlat   (tableFlat)
  );

endmodule

// File: rtl/rename_checker.sv
module rename_checker #(
  parameter int NUM_ARCH = 8,
  parameter int TAG_W    = 4,
  localparam int IDX_W   = $clog2(NUM_ARCH),
  localparam int ENT_W   = TAG_W + 1
) (
  input logic                      clk,
  input logic                      rstN,
  input logic                      renValid,
  input logic [TAG_W-1:0]          renTag,
  input logic                      dstValid,
  input logic [IDX_W-1:0]          dstIdx,
  input logic                      squash,
  input logic [NUM_ARCH*ENT_W-1:0] commitTable,
  input logic [NUM_ARCH*ENT_W-1:0] tableFlat,
  input logic [1:0]                srcReady,
  input logic [1:0]                depValid,
  input logic                      prevValid
);

  function automatic logic [ENT_W-1:0] entryAt(logic [NUM_ARCH*ENT_W-1:0] flat,
                                               logic [IDX_W-1:0] idx);
    return flat[idx*ENT_W +: ENT_W];
  endfunction

  a_r7_restore: assert property (@(posedge clk) disable iff (!rstN)
    squash |=> tableFlat == $past(commitTable));

  a_r4_dst_written: assert property (@(posedge clk) disable iff (!rstN)
    (renValid && dstValid && !squash) |=> entryAt(tableFlat, $past(dstIdx)) == {1'b1, $past(renTag)});

  a_r3_dep_not_ready: assert property (@(posedge clk) disable iff (!rstN)
    (depValid != 2'b00) |-> ((depValid & srcReady) == 2'b00));

  a_r8_idle_quiet: assert property (@(posedge clk) disable iff (!rstN)
    !renValid |-> (depValid == 2'b00 && !prevValid));

  a_r8_idle_stable: assert property (@(posedge clk) disable iff (!rstN)
    (!renValid && !squash) |=> $stable(tableFlat));

  a_r7_no_prev_on_squash: assert property (@(posedge clk) disable iff (!rstN)
    squash |-> !prevValid);

endmodule

bind producer_tag_rename rename_checker #(.NUM_ARCH(NUM_ARCH), .TAG_W(TAG_W)) u_chk (
  .clk         (clk),
  .rstN        (rstN),
  .renValid    (renValid),
  .renTag      (renTag),
  .dstValid    (dstValid),
  .dstIdx      (dstIdx),
  .squash      (squash),
  .commitTable (commitTable),
  .tableFlat   (tableFlat),
  .srcReady    (srcReady),
  .depValid    (depValid),
  .prevValid   (prevValid)
);

// File: tb/producer_tag_rename_bench.sv
`timescale 1ns/1ps
module producer_tag_rename_bench;

  localparam int NUM_ARCH = 8;
  localparam int TAG_W    = 4;
  localparam int IDX_W    = 3;
  localparam int ENT_W    = TAG_W + 1;

  logic                      clk = 0;
  logic                      rstN;
  logic                      renValid;
  logic [TAG_W-1:0]          renTag;
  logic [1:0]                srcValid;
  logic [2*IDX_W-1:0]        srcIdx;
  logic                      dstValid;
  logic [IDX_W-1:0]          dstIdx;
  logic                      wbValid;
  logic [TAG_W-1:0]          wbTag;
  logic                      squash;
  logic [NUM_ARCH*ENT_W-1:0] commitTable;
  logic [1:0]                srcReady;
  logic [1:0]                depValid;
  logic [2*TAG_W-1:0]        depTag;
  logic                      prevValid;
  logic [TAG_W-1:0]          prevTag;

  int  checks   = 0;
  int  failures = 0;
  bit  done     = 0;

  always #2.5 clk = ~clk;

  producer_tag_rename u_producer_tag_rename (
    .clk(clk), .rstN(rstN), .renValid(renValid), .renTag(renTag),
    .srcValid(srcValid), .srcIdx(srcIdx), .dstValid(dstValid), .dstIdx(dstIdx),
    .wbValid(wbValid), .wbTag(wbTag), .squash(squash), .commitTable(commitTable),
    .srcReady(srcReady), .depValid(depValid), .depTag(depTag),
    .prevValid(prevValid), .prevTag(prevTag)
  );

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic idle();
    renValid = 0; renTag = 0; srcValid = 0; srcIdx = 0;
    dstValid = 0; dstIdx = 0; wbValid = 0; wbTag = 0; squash = 0;
  endtask

  task automatic setRen(int tag, bit s0v, int s0, bit s1v, int s1, bit dv, int d);
    renValid = 1; renTag = TAG_W'(tag);
    srcValid = {s1v, s0v};
    srcIdx   = {IDX_W'(s1), IDX_W'(s0)};
    dstValid = dv; dstIdx = IDX_W'(d);
  endtask

  // Tasks start just after a falling edge and end on one.
  task automatic nextCycle();
    @(negedge clk);
    idle();
  endtask

  task automatic t_reset();
    setRen(1, 1, 3, 1, 7, 1, 0); #1;
    chk("R1 src0 ready", srcReady[0], 1);
    chk("R1 src1 ready", srcReady[1], 1);
    chk("R1 no deps", depValid, 0);
    chk("R1 no prev", prevValid, 0);
    squash = 1; #1; nextCycle(); // discard the rename, keep table empty
  endtask

  task automatic t_dest_chain();
    commitTable = '0;
    setRen(5, 0, 0, 0, 0, 1, 2); #1;
    chk("R4 empty old entry", prevValid, 0);
    nextCycle();
    setRen(4, 0, 2, 0, 2, 0, 0); #1;   // sources invalid though r2 pending
    chk("R2 no-source ready", srcReady, 3);
    chk("R2 no-source no dep", depValid, 0);
    nextCycle();
    setRen(6, 1, 2, 1, 3, 1, 2); #1;
    chk("R3 dep on pending", depValid[0], 1);
    chk("R3 not ready", srcReady[0], 0);
    chk("R5 older producer", depTag[TAG_W-1:0], 5);
    chk("R3 empty entry ready", srcReady[1], 1);
    chk("R4 prev valid", prevValid, 1);
    chk("R4 prev tag", prevTag, 5);
    nextCycle();
    setRen(7, 1, 2, 0, 0, 0, 0); #1;
    chk("R4 entry overwritten", depTag[TAG_W-1:0], 6);
    nextCycle();
  endtask

  task automatic t_writeback();
    wbValid = 1; wbTag = 6; #1;
    chk("R8 idle no dep", depValid, 0);
    chk("R8 idle no prev", prevValid, 0);
    nextCycle();
    setRen(8, 1, 2, 0, 0, 0, 0); #1;
    chk("R6 ready after wb", srcReady[0], 1);
    chk("R6 no dep after wb", depValid[0], 0);
    nextCycle();
    setRen(9, 0, 0, 0, 0, 1, 4); wbValid = 1; wbTag = 9; #1;
    nextCycle();
    setRen(10, 1, 4, 0, 0, 0, 0); #1;
    chk("R6 allocation wins", depValid[0], 1);
    chk("R6 collision tag", depTag[TAG_W-1:0], 9);
    nextCycle();
    wbValid = 1; wbTag = 9; nextCycle();
    setRen(11, 1, 4, 0, 0, 0, 0); #1;
    chk("R6 later wb ready", srcReady[0], 1);
    nextCycle();
  endtask

  task automatic t_squash();
    commitTable = '0;
    commitTable[0*ENT_W +: ENT_W] = {1'b1, 4'd12};
    commitTable[5*ENT_W +: ENT_W] = {1'b1, 4'd6};
    squash = 1; setRen(3, 0, 0, 0, 0, 1, 1); #1;
    chk("R7 no prev on squash", prevValid, 0);
    nextCycle();
    setRen(13, 1, 0, 1, 5, 0, 0); #1;
    chk("R7 restored pending", depValid[0], 1);
    chk("R7 restored tag", depTag[TAG_W-1:0], 12);
    chk("R7 restored ready producer", srcReady[1], 1);
    nextCycle();
    setRen(14, 1, 1, 1, 2, 0, 0); #1;
    chk("R7 squashed rename dropped", srcReady[0], 1);
    chk("R7 live entry cleared", srcReady[1], 1);
    nextCycle();
  endtask

  initial begin
    idle(); commitTable = '0; rstN = 0;
    repeat (3) @(posedge clk);
    @(negedge clk); rstN = 1;
    t_reset();
    t_dest_chain();
    t_writeback();
    t_squash();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule